// File: doc/BRIEF.md
# Store Acknowledgement Fence Tracker

This block sits between the decode and execute stages of an in-order pipelined accumulator processor. It keeps the decode stage from issuing a new instruction while any store that the pipeline has sent to memory is still waiting for its acknowledgement. It counts stores as decode issues them. It counts acknowledgements as they come back from memory. It also keeps a committed-store count that the execute stage maintains. When the pipeline restarts, the speculative issue count is reloaded from the committed count.

The fence is a three-state machine. `FS_OPEN` means the issued and acknowledged counts are equal, so issue is allowed. `FS_WAIT` means stores are outstanding, so issue is held. `FS_FAULT` means the acknowledged count has passed the issued count; this is sticky and holds issue until reset.

The transitions are:
- `open_to_wait`: an issued store makes the counts differ.
- `wait_to_open`: the last acknowledgement arrives.
- `any_to_fault`: the next-cycle signed difference (issued minus acknowledged) is negative.
- `fault_hold`: the machine stays in `FS_FAULT` in every cycle until reset.

The decision is made from the next-cycle counter values, so the state registered at a clock edge describes the counters that are registered at that same edge.

Top module: `store_fence_tracker`

## Requirements
- R1: A synchronous active-high reset clears the issued, acknowledged and committed counts to zero, lowers `error`, and holds `issue_en` low while asserted.
- R2: `issue_en` is high exactly when `issue_req` is high, the registered issued and acknowledged counts are equal, `error` is low and `restart` is low.
- R3: In a cycle where `issue_en` is high, the issued count rises by `issue_autoinc_st + issue_exec_st` (0, 1 or 2) at the next edge. With `issue_en` low, these flags have no effect.
- R4: Each cycle with `mem_st_ack` high adds exactly one to the acknowledged count.
- R5: An acknowledgement and an issue in the same cycle both update their counts at that edge. The fence for that cycle uses the values registered before it.
- R6: A cycle with `ex_commit` high adds `ex_commit_autoinc + ex_commit_exec_st` to the committed count. With `ex_commit` low, these two flags have no effect.
- R7: A cycle with `ex_squash_autoinc` high adds two to the committed count: one for the original store and one for the compensating undo store. This adds to any commit increment in the same cycle.
- R8: When `restart` is high, the issued count is loaded with the committed count as updated in that same cycle, and any issue in that cycle is refused.
- R9: If the next-cycle difference (issued minus acknowledged), taken modulo 2^CNT_W and read as a signed two's-complement value, is negative, `error` goes high at that edge. It stays high until reset, and while it is high `issue_en` stays low.
- R10: All counts are CNT_W bits wide and wrap modulo 2^CNT_W. An equal pair of counts opens the fence even after wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_req | input | 1 | Decode holds a fetched instruction and all its downstream ports can accept it |
| issue_autoinc_st | input | 1 | The instruction at decode will send an auto-increment store |
| issue_exec_st | input | 1 | The instruction at decode will send an execute-stage store |
| mem_st_ack | input | 1 | Store completion pulse from memory |
| ex_commit | input | 1 | Execute commits an instruction this cycle |
| ex_commit_autoinc | input | 1 | The committed instruction carried an auto-increment store |
| ex_commit_exec_st | input | 1 | The committed instruction sends an execute-stage store |
| ex_squash_autoinc | input | 1 | Execute squashes an instruction whose auto-increment store was already sent, and sends an undo store |
| restart | input | 1 | Pipeline restart request |
| issue_en | output | 1 | Decode may issue this cycle |
| sent_cnt | output | CNT_W | Speculative issued-store count |
| done_cnt | output | CNT_W | Acknowledged-store count |
| commit_cnt | output | CNT_W | Committed-store count kept for execute |
| error | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that the environment follows the handshake: decode treats an instruction as issued only in a cycle where `issue_en` is high, and each acknowledgement is a single-cycle pulse. They also assume that a restart means execute's committed count is the authoritative store tally.

The stimulus applies the inputs only as that handshake allows. It drives a deterministic sweep of all nine input bits, runs the counters with a narrow 4-bit configuration so that wrapping and sign reversal are reached quickly, and resets whenever the fault state is entered. Acknowledgements that would underflow are applied on purpose only in the directed fault test.

// File: rtl/store_fence_pkg.sv
package store_fence_pkg;

    typedef enum logic [1:0] {
        FS_OPEN  = 2'd0,
        FS_WAIT  = 2'd1,
        FS_FAULT = 2'd2
    } fence_state_t;

endpackage

// File: rtl/fence_counter.sv
module fence_counter #(
    parameter int W     = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     q,
    output logic [W-1:0]     q_next
);

    always_comb begin
        if (load) q_next = load_val;
        else      q_next = q + W'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // R3 R4 R6: without a load the count advances by exactly the increment
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> q == $past(q) + W'($past(inc)));

    // R8: a load takes the supplied value
    assert_count_load_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(load_val));

endmodule

// File: rtl/fence_fsm.sv
module fence_fsm
    import store_fence_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sent_next,
    input  logic [W-1:0] done_next,
    output logic         fence_open,
    output logic         fault
);

    fence_state_t state, state_next;
    logic [W-1:0] diff_next;

    assign diff_next = sent_next - done_next;

    always_comb begin
        unique case (state)
            FS_FAULT: state_next = FS_FAULT;
            FS_OPEN, FS_WAIT: begin
                if (diff_next[W-1])        state_next = FS_FAULT;
                else if (diff_next == '0)  state_next = FS_OPEN;
                else                       state_next = FS_WAIT;
            end
            default: state_next = FS_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FS_OPEN;
        else     state <= state_next;
    end

    always_comb begin
        fence_open = 1'b0;
        fault      = 1'b0;
        unique case (state)
            FS_OPEN:  fence_open = 1'b1;
            FS_WAIT:  fence_open = 1'b0;
            FS_FAULT: fault      = 1'b1;
            default:  fault      = 1'b1;
        endcase
    end

    // R9: once entered, the fault state persists until reset
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R2: open and fault are never presented together
    assert_open_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(fence_open && fault));

endmodule

// File: rtl/store_fence_tracker.sv
module store_fence_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_req,
    input  logic             issue_autoinc_st,
    input  logic             issue_exec_st,
    input  logic             mem_st_ack,
    input  logic             ex_commit,
    input  logic             ex_commit_autoinc,
    input  logic             ex_commit_exec_st,
    input  logic             ex_squash_autoinc,
    input  logic             restart,
    output logic             issue_en,
    output logic [CNT_W-1:0] sent_cnt,
    output logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] commit_cnt,
    output logic             error
);

    localparam int INC_W = 3;

    logic               fence_open;
    logic [INC_W-1:0]   sent_inc, done_inc, commit_inc;
    logic [CNT_W-1:0]   sent_next, done_next, commit_next;

    assign issue_en = issue_req && fence_open && !restart && !rst;

    always_comb begin
        sent_inc   = '0;
        commit_inc = '0;
        if (issue_en)
            sent_inc = INC_W'(issue_autoinc_st) + INC_W'(issue_exec_st);
        if (ex_commit)
            commit_inc = INC_W'(ex_commit_autoinc) + INC_W'(ex_commit_exec_st);
        if (ex_squash_autoinc)
            commit_inc = commit_inc + INC_W'(2);
        done_inc = INC_W'(mem_st_ack);
    end

    fence_counter #(.W(CNT_W), .INC_W(INC_W)) i_commit_ctr (
        .clk(clk), .rst(rst), .load(1'b0), .load_val('0),
        .inc(commit_inc), .q(commit_cnt), .q_next(commit_next)
    );

    fence_counter #(.W(CNT_W), .INC_W(INC_W)) i_sent_ctr (
        .clk(clk), .rst(rst), .load(restart), .load_val(commit_next),
        .inc(sent_inc), .q(sent_cnt), .q_next(sent_next)
    );

    fence_counter #(.W(CNT_W), .INC_W(INC_W)) i_done_ctr (
        .clk(clk), .rst(rst), .load(1'b0), .load_val('0),
        .inc(done_inc), .q(done_cnt), .q_next(done_next)
    );

    fence_fsm #(.W(CNT_W)) i_fsm (
        .clk(clk), .rst(rst), .sent_next(sent_next), .done_next(done_next),
        .fence_open(fence_open), .fault(error)
    );

    // R2: issue is only granted with balanced counters and no fault
    assert_fence_gate_R2: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> (sent_cnt == done_cnt) && !error);

    // R8: a restart cycle never grants issue
    assert_restart_refuse_R8: assert property (@(posedge clk) disable iff (rst)
        restart |-> !issue_en);

    // R8: after a restart the issued count equals the committed count
    assert_restart_sync_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> sent_cnt == commit_cnt);

    // R4: an acknowledgement moves the acknowledged count by one
    assert_ack_step_R4: assert property (@(posedge clk) disable iff (rst)
        mem_st_ack |=> done_cnt == $past(done_cnt) + CNT_W'(1));

    // R1: reset state
    always_ff @(posedge clk) begin
        if ($past(rst) && !rst)
            assert_reset_clear_R1: assert (sent_cnt == '0 && done_cnt == '0
                                           && commit_cnt == '0 && !error);
    end

endmodule

// File: tb/test_store_fence_tracker.sv
module test_store_fence_tracker;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_req = 0, issue_autoinc_st = 0, issue_exec_st = 0, mem_st_ack = 0;
    logic ex_commit = 0, ex_commit_autoinc = 0, ex_commit_exec_st = 0;
    logic ex_squash_autoinc = 0, restart = 0;
    logic         issue_en, error;
    logic [W-1:0] sent_cnt, done_cnt, commit_cnt;

    int n_vec = 0, n_bad = 0;
    int m_sent = 0, m_done = 0, m_commit = 0, m_err = 0;
    int last_issue = 0;

    always #5 clk = ~clk;

    store_fence_tracker #(.CNT_W(W)) i_store_fence_tracker (
        .clk(clk), .rst(rst), .issue_req(issue_req),
        .issue_autoinc_st(issue_autoinc_st), .issue_exec_st(issue_exec_st),
        .mem_st_ack(mem_st_ack), .ex_commit(ex_commit),
        .ex_commit_autoinc(ex_commit_autoinc), .ex_commit_exec_st(ex_commit_exec_st),
        .ex_squash_autoinc(ex_squash_autoinc), .restart(restart),
        .issue_en(issue_en), .sent_cnt(sent_cnt), .done_cnt(done_cnt),
        .commit_cnt(commit_cnt), .error(error)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {issue_req, issue_autoinc_st, issue_exec_st, mem_st_ack, ex_commit,
         ex_commit_autoinc, ex_commit_exec_st, ex_squash_autoinc, restart} = '0;
        issue_req = 1'b1;
        #1 chk("R1", int'(issue_en), 0);
        issue_req = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        m_sent = 0; m_done = 0; m_commit = 0; m_err = 0;
        chk("R1", int'(sent_cnt), 0);
        chk("R1", int'(done_cnt), 0);
        chk("R1", int'(commit_cnt), 0);
        chk("R1", int'(error), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input bit rq, ai, es, ak, cm, cai, ces, sq, rs);
        int iss, inc_c, d;
        @(negedge clk);
        issue_req = rq; issue_autoinc_st = ai; issue_exec_st = es;
        mem_st_ack = ak; ex_commit = cm; ex_commit_autoinc = cai;
        ex_commit_exec_st = ces; ex_squash_autoinc = sq; restart = rs;
        #1;
        iss = (rq && m_sent == m_done && !rs && !m_err) ? 1 : 0;
        last_issue = int'(issue_en);
        chk("R2", int'(issue_en), iss);
        inc_c = (cm ? int'(cai) + int'(ces) : 0) + (sq ? 2 : 0);
        m_commit = (m_commit + inc_c) & MASK;
        if (rs) m_sent = m_commit;
        else if (iss != 0) m_sent = (m_sent + int'(ai) + int'(es)) & MASK;
        m_done = (m_done + int'(ak)) & MASK;
        d = (m_sent - m_done) & MASK;
        if (d >= (1 << (W - 1))) m_err = 1;
        @(posedge clk);
        #1;
        chk(rs ? "R8" : "R3", int'(sent_cnt), m_sent);
        chk("R4", int'(done_cnt), m_done);
        chk(sq ? "R7" : "R6", int'(commit_cnt), m_commit);
        chk("R9", int'(error), m_err);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R3: one issue carrying both store kinds adds two
        step(1,1,1, 0, 0,0,0, 0, 0);
        chk("R3", int'(sent_cnt), 2);
        // R2: outstanding stores hold issue
        step(1,1,0, 0, 0,0,0, 0, 0);
        chk("R2", last_issue, 0);
        chk("R3", int'(sent_cnt), 2);
        step(0,0,0, 1, 0,0,0, 0, 0);
        step(0,0,0, 1, 0,0,0, 0, 0);
        chk("R4", int'(done_cnt), 2);
        // R5: ack and issue in the same cycle
        step(1,1,0, 1, 0,0,0, 0, 0);
        chk("R5", last_issue, 1);
        chk("R5", int'(sent_cnt), 3);
        chk("R5", int'(done_cnt), 3);
        // R6: commit adds its flags; flags ignored without commit
        step(0,0,0, 0, 1,1,1, 0, 0);
        chk("R6", int'(commit_cnt), 2);
        step(0,0,0, 0, 0,1,1, 0, 0);
        chk("R6", int'(commit_cnt), 2);
        // R7: squash costs two, added to a same-cycle commit
        step(0,0,0, 0, 1,1,0, 1, 0);
        chk("R7", int'(commit_cnt), 5);
        // R8: restart loads the updated committed count and refuses issue
        step(1,1,1, 0, 1,0,1, 0, 1);
        chk("R8", last_issue, 0);
        chk("R8", int'(sent_cnt), 6);
        // R9: acknowledging past the issued count faults and holds
        for (int k = 0; k < 4; k++) step(0,0,0, 1, 0,0,0, 0, 0);
        chk("R9", int'(error), 1);
        step(0,0,0, 1, 0,0,0, 0, 0);
        step(1,0,0, 0, 0,0,0, 0, 0);
        chk("R9", last_issue, 0);
        chk("R9", int'(error), 1);

        // R10: wrap both counts through 2^W and reopen
        do_reset();
        for (int k = 0; k < 8; k++) begin
            step(1,1,1, 0, 0,0,0, 0, 0);
            step(0,0,0, 1, 0,0,0, 0, 0);
            step(0,0,0, 1, 0,0,0, 0, 0);
        end
        chk("R10", int'(sent_cnt), 0);
        chk("R10", int'(done_cnt), 0);
        step(1,0,0, 0, 0,0,0, 0, 0);
        chk("R10", last_issue, 1);
        chk("R10", int'(error), 0);

        // Sweep over all nine input bits, reset on fault
        do_reset();
        for (int n = 0; n < 4096; n++) begin
            int p;
            bit ak;
            p = (n * 37 + (n >> 9)) & 511;
            ak = p[3] && (m_sent != m_done);
            step(p[0], p[1], p[2], ak, p[4], p[5], p[6], p[7], p[8] && (n % 7 == 0));
            if (m_err != 0) do_reset();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule